// File: doc/BRIEF.md
# Interrupt Level Aggregator

This block gathers thirteen level-sensitive interrupt request lines into a single 4-bit encoded level presented to a CPU. Each request line has its own enable bit in a 16-bit mask register, and each has a fixed priority level. The enable bits are scattered across the mask word rather than packed in order. Among the lines that are both high and enabled, the one with the smallest level number wins. The block drives the bitwise inverse of that level as a registered code. When nothing qualifies the code is zero.

A small 16-bit register window of 0x40 bytes sits next to the aggregator. It holds the interrupt mask, a general-purpose output-port register, a constant identification word, and a power-off control. A write to the power-off control produces a one-cycle shutdown request. The bus port is synchronous: the select, write enable, byte address and write data are taken at a clock edge, and read data appears in the following cycle.

Top module: `irq_level_agg`

## Requirements
- R1: While `rst_n` is low at a clock edge, the mask register, the output-port register, `irl_code`, `shutdown_req` and `bus_rdata` all become 0.
- R2: A request line has no memory. Its effect on `irl_code` lasts only while it is high, and the code returns once the line drops.
- R3: Request line `src_req[i]` has priority level i. Its enable bit in the mask is, for i = 0..12 in turn: 11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15. A line whose enable bit is 0 has no effect.
- R4: `irl_code` equals 15 minus the smallest qualifying level. It is 0 when no line qualifies, and 15 when line 0 qualifies.
- R5: `irl_code` is registered. It reflects the request lines and mask register as they stood at the previous clock edge. After a mask write, it therefore shows the new mask one edge after the write edge.
- R6: Byte offset 0x00 is the mask register, readable and writable over all 16 bits.
- R7: Byte offset 0x36 is a 16-bit readable and writable register whose value drives `out_port`.
- R8: Byte offset 0x32 always reads 0x0010, and writes to it change nothing.
- R9: A write to byte offset 0x30 with data bit 0 set makes `shutdown_req` high for exactly the one cycle after the write edge. A write with bit 0 clear does not. Reads of 0x30 return 0.
- R10: Every other offset, odd offsets included, reads as 0, and writes to such offsets change no register.
- R11: `bus_rdata` holds the addressed value in the cycle after a read select, and is 0 after any cycle that was not a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | Access is a write when high |
| bus_addr | input | 6 | Byte offset within the window |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after the select |
| src_req | input | 13 | Level-sensitive request lines, bit i has level i |
| irl_code | output | 4 | Inverted winning level, 0 when idle |
| out_port | output | 16 | Contents of the output-port register |
| shutdown_req | output | 1 | One-cycle power-off request |

## Verification
A mask write and a change on the request lines can land on the same clock edge. The registered code then takes the new request pattern but still uses the old mask for one cycle. The bench provokes this by switching a request line in the same cycle it writes a mask that disables the old winner and enables the new one. It then checks the code at the first edge against the old mask and new lines, and at the next edge against the new mask. Separately, every one of the 8192 request patterns is swept under several masks, and each code is compared with a value computed from the level and enable-bit table.

// File: rtl/irq_agg_pkg.sv
// Shared constants for the interrupt level aggregator: window offsets,
// widths and the fixed map from request line to mask enable bit.
// Assumes the request line index is also its priority level.
package irq_agg_pkg;

    localparam int NUM_SRC = 13;
    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 6;
    localparam int LVL_W   = 4;

    localparam logic [ADDR_W-1:0] OFF_MASK = 6'h00;
    localparam logic [ADDR_W-1:0] OFF_PWR  = 6'h30;
    localparam logic [ADDR_W-1:0] OFF_ID   = 6'h32;
    localparam logic [ADDR_W-1:0] OFF_OUT  = 6'h36;

    localparam logic [DATA_W-1:0] ID_VALUE = 16'h0010;

    // Mask bit that enables the request line of the given level.
    function automatic int en_bit_of(input int idx);
        case (idx)
            0:       return 11;
            1:       return 9;
            2:       return 8;
            3:       return 12;
            4:       return 10;
            5:       return 6;
            6:       return 5;
            7:       return 4;
            8:       return 7;
            9:       return 14;
            10:      return 13;
            11:      return 0;
            12:      return 15;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/irq_agg_regs.sv
// Register window of the aggregator: mask, output port, constant
// identification word and power-off control. Assumes single-cycle
// 16-bit accesses; read data is registered and returned next cycle.
module irq_agg_regs #(
    parameter int DATA_W = irq_agg_pkg::DATA_W,
    parameter int ADDR_W = irq_agg_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] port_q,
    output logic              shut_q
);
    import irq_agg_pkg::*;

    logic              wr_en;
    logic              rd_en;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en = sel && we;
    assign rd_en = sel && !we;

    // Select the read value for the addressed offset.
    always_comb begin
        case (addr)
            OFF_MASK: rd_mux = mask_q;
            OFF_OUT:  rd_mux = port_q;
            OFF_ID:   rd_mux = ID_VALUE;
            default:  rd_mux = '0;
        endcase
    end

    // Hold the mask and output-port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            port_q <= '0;
        end else if (wr_en) begin
            if (addr == OFF_MASK) mask_q <= wdata;
            if (addr == OFF_OUT)  port_q <= wdata;
        end
    end

    // Raise a one-cycle shutdown request on a qualifying power-off write.
    always_ff @(posedge clk) begin
        if (!rst_n) shut_q <= 1'b0;
        else        shut_q <= wr_en && (addr == OFF_PWR) && wdata[0];
    end

    // Register read data; zero after any non-read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
        else            rdata <= '0;
    end

endmodule

// File: rtl/irq_agg_qual.sv
// Qualifies each request line with its scattered mask enable bit.
// Assumes the map from line to bit in irq_agg_pkg fits inside MASK_W.
module irq_agg_qual #(
    parameter int NUM_SRC = irq_agg_pkg::NUM_SRC,
    parameter int MASK_W  = irq_agg_pkg::DATA_W
) (
    input  logic [NUM_SRC-1:0] src,
    input  logic [MASK_W-1:0]  mask,
    output logic [NUM_SRC-1:0] qual
);
    // One AND gate per line, picking its own enable bit.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        localparam int EB = irq_agg_pkg::en_bit_of(g);
        assign qual[g] = src[g] & mask[EB];
    end

endmodule

// File: rtl/irq_agg_prio.sv
// Finds the lowest qualifying level and registers its inverse as the
// output code. Assumes NUM_SRC is below 2**LVL_W so the idle level
// (all ones) never collides with a real level.
module irq_agg_prio #(
    parameter int NUM_SRC = irq_agg_pkg::NUM_SRC,
    parameter int LVL_W   = irq_agg_pkg::LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] qual,
    output logic [LVL_W-1:0]   code_q
);
    localparam logic [LVL_W-1:0] IDLE_LVL = '1;

    logic [LVL_W-1:0] win_lvl;

    // Scan from the highest level down so the lowest qualifier wins.
    always_comb begin
        win_lvl = IDLE_LVL;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (qual[i]) win_lvl = LVL_W'(i);
        end
    end

    // Register the inverted winning level.
    always_ff @(posedge clk) begin
        if (!rst_n) code_q <= '0;
        else        code_q <= ~win_lvl;
    end

endmodule

// File: rtl/irq_level_agg.sv
// Top of the interrupt level aggregator: register window, per-line
// qualification and priority encoding. Assumes a single clock and a
// synchronous active-low reset.
module irq_level_agg #(
    parameter int NUM_SRC = irq_agg_pkg::NUM_SRC,
    parameter int DATA_W  = irq_agg_pkg::DATA_W,
    parameter int ADDR_W  = irq_agg_pkg::ADDR_W,
    parameter int LVL_W   = irq_agg_pkg::LVL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [NUM_SRC-1:0] src_req,
    output logic [LVL_W-1:0]   irl_code,
    output logic [DATA_W-1:0]  out_port,
    output logic               shutdown_req
);
    logic [DATA_W-1:0]  mask_q;
    logic [NUM_SRC-1:0] qual;

    irq_agg_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .we     (bus_we),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .mask_q (mask_q),
        .port_q (out_port),
        .shut_q (shutdown_req)
    );

    irq_agg_qual #(.NUM_SRC(NUM_SRC), .MASK_W(DATA_W)) u_qual (
        .src  (src_req),
        .mask (mask_q),
        .qual (qual)
    );

    irq_agg_prio #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) u_prio (
        .clk    (clk),
        .rst_n  (rst_n),
        .qual   (qual),
        .code_q (irl_code)
    );

endmodule

// File: rtl/irq_agg_checker.sv
// Temporal checks on the aggregator ports and its mask register.
// Assumes the default configuration (13 lines, 16-bit window).
module irq_agg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        sel,
    input logic        we,
    input logic [5:0]  addr,
    input logic        pwr_bit,
    input logic [15:0] rdata,
    input logic [12:0] src_req,
    input logic [15:0] mask_q,
    input logic [3:0]  irl_code,
    input logic        shut
);
    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(src_req) == 13'd0 |-> irl_code == 4'd0); // R2
    AST_TOP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(src_req[0] && mask_q[11]) |-> irl_code == 4'hF); // R4
    AST_ID_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sel && !we && addr == 6'h32) |-> rdata == 16'h0010); // R8
    AST_PWR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sel && !we && addr == 6'h30) |-> rdata == 16'h0000); // R9
    AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && shut |-> $past(sel && we && addr == 6'h30 && pwr_bit)); // R9
    AST_OTHER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && sel && !we && addr == 6'h10) |-> rdata == 16'h0000); // R10
    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(sel && !we) |-> rdata == 16'h0000); // R11

endmodule

bind irq_level_agg irq_agg_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (bus_sel),
    .we       (bus_we),
    .addr     (bus_addr),
    .pwr_bit  (bus_wdata[0]),
    .rdata    (bus_rdata),
    .src_req  (src_req),
    .mask_q   (mask_q),
    .irl_code (irl_code),
    .shut     (shutdown_req)
);

// File: tb/irq_level_agg_bench.sv
// Self-checking bench: near-exhaustive sweep of request patterns under
// several masks, plus register window and timing corner cases.
module irq_level_agg_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [12:0] src_req = '0;
    logic [3:0]  irl_code;
    logic [15:0] out_port;
    logic        shutdown_req;

    int total = 0;
    int bad = 0;
    bit done = 0;

    localparam int EN_BIT [13] = '{11, 9, 8, 12, 10, 6, 5, 4, 7, 14, 13, 0, 15};

    always #5 clk = ~clk;

    irq_level_agg u_irq_level_agg (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_sel      (bus_sel),
        .bus_we       (bus_we),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_rdata    (bus_rdata),
        .src_req      (src_req),
        .irl_code     (irl_code),
        .out_port     (out_port),
        .shutdown_req (shutdown_req)
    );

    function automatic logic [3:0] exp_code(input logic [12:0] s, input logic [15:0] m);
        int lvl = 15;
        for (int i = 12; i >= 0; i--) begin
            if (s[i] && m[EN_BIT[i]]) lvl = i;
        end
        return 4'(lvl ^ 15);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] masks [4] = '{16'hFFFF, 16'h0000, 16'hA5C3, 16'h5A3C};

        // R1: reset state with all lines high
        src_req = '1;
        repeat (2) @(negedge clk);
        chk("R1 code", irl_code, 0);
        chk("R1 shut", shutdown_req, 0);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 port", out_port, 0);
        rst_n = 1'b1;
        rd(6'h00, v); chk("R1 mask", v, 0);
        // R3: all lines high but mask clear leaves code at 0
        @(negedge clk); chk("R3 masked", irl_code, 0);

        // R2 / R4: single line follows its level without latching
        src_req = '0;
        wr(6'h00, 16'hFFFF);
        @(negedge clk); src_req = 13'h0020;
        @(negedge clk); chk("R2 high", irl_code, 4'd10);
        src_req = '0;
        @(negedge clk); chk("R2 drop", irl_code, 0);

        // R5: code lags an input change by exactly one edge
        @(negedge clk); src_req = 13'h0001;
        @(posedge clk); #1 chk("R5 lag", irl_code, 4'hF);

        // R5: coincident mask write and request change
        @(negedge clk);
        src_req = 13'h0010;
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 6'h00; bus_wdata = 16'h0400;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
        chk("R5 old mask", irl_code, exp_code(13'h0010, 16'hFFFF));
        @(negedge clk);
        chk("R5 new mask", irl_code, exp_code(13'h0010, 16'h0400));

        // R3 / R4: sweep all request patterns under several masks
        foreach (masks[k]) begin
            wr(6'h00, masks[k]);
            for (int s = 0; s < 8192; s++) begin
                src_req = 13'(s);
                @(negedge clk);
                chk("R4 sweep", irl_code, exp_code(13'(s), masks[k]));
            end
        end
        src_req = '0;

        // R6: mask readback
        wr(6'h00, 16'h3C5A); rd(6'h00, v); chk("R6 mask rd", v, 16'h3C5A);
        // R7: output port
        wr(6'h36, 16'hBEEF); rd(6'h36, v); chk("R7 port rd", v, 16'hBEEF);
        chk("R7 port pin", out_port, 16'hBEEF);
        // R8: identification word, write ignored
        wr(6'h32, 16'hFFFF); rd(6'h32, v); chk("R8 id", v, 16'h0010);
        // R9: power-off pulse and read
        wr(6'h30, 16'h0001); chk("R9 pulse", shutdown_req, 1);
        @(negedge clk); chk("R9 single", shutdown_req, 0);
        wr(6'h30, 16'hFFFE); chk("R9 bit0 clear", shutdown_req, 0);
        rd(6'h30, v); chk("R9 read", v, 0);
        // R10: other offsets read 0, writes touch nothing
        wr(6'h02, 16'hFFFF); wr(6'h37, 16'h0000); wr(6'h3E, 16'h1234);
        rd(6'h02, v); chk("R10 rd02", v, 0);
        rd(6'h01, v); chk("R10 rd01", v, 0);
        rd(6'h00, v); chk("R10 mask kept", v, 16'h3C5A);
        rd(6'h36, v); chk("R10 port kept", v, 16'hBEEF);
        // R11: read data returns to 0 after the read cycle
        @(negedge clk); chk("R11 idle", bus_rdata, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule